// File: doc/BRIEF.md
# Graduated Hysteretic Recovery Controller

This block turns a stream of confirmed fault-severity epochs, already filtered for persistence upstream, into mitigation commands for a chip's power and reliability hardware. It keeps a mitigation tier. Nominal operation is tier 0. Tier 1 lowers the clock. Tier 2 lowers both clock and supply. Tier 3 lowers both further, fires a one-cycle reset at the implicated module and then holds a request for redundant compute to take over.

Escalation is quick, but it needs evidence. A short run of consecutive epochs that report a severity above the present tier moves the controller straight to the reported tier. Relaxation is slow. Only a programmable run of consecutive all-clear epochs lowers the tier, and it lowers it by one step. The calm count then restarts, so full performance returns gradually. Monitoring goes on at every tier, and any non-clear epoch during a calm run discards the progress made so far.

Top module: `recov_ctrl`

## Requirements
- R1: After synchronous reset, the tier is 0, `freq_lvl` and `volt_lvl` are 0, and `rst_pulse` and `handoff_req` are low.
- R2: The severity encoding is 0 = clear, 1 = degrading, 2 = severe, 3 = critical. Only cycles with `sev_valid` high are epochs.
- R3: With ESC_HOLD = 2, the tier rises only after 2 consecutive epochs whose severity is above the current tier. It then takes the severity of the last of those epochs. An epoch at or below the current tier restarts this count.
- R4: In tier 1, `freq_lvl` is 1 and `volt_lvl` is 0.
- R5: In tier 2, `freq_lvl` is 2 and `volt_lvl` is 1.
- R6: In tier 3, `freq_lvl` is 3 and `volt_lvl` is 2. `rst_pulse` is high for exactly the one cycle in which tier 3 is entered. `handoff_req` rises the cycle after that and stays high while the tier remains 3.
- R7: `calm_period` consecutive clear epochs lower a non-zero tier by exactly one, and the calm count then restarts. A `calm_period` of 0 acts as 1.
- R8: Any valid non-clear epoch clears the calm count. A non-clear epoch at or below the current tier changes nothing else.
- R9: The tier steps down one level at a time, never more. `handoff_req` falls in the same cycle that tier 3 is left.
- R10: Cycles with `sev_valid` low have no effect, whatever `sev` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sev_valid | input | 1 | Marks a cycle that carries a confirmed severity epoch |
| sev | input | 2 | Confirmed severity class (0 clear to 3 critical) |
| calm_period | input | CALM_W | Clear epochs needed per one-tier step down |
| freq_lvl | output | 2 | Frequency reduction level, 0 nominal |
| volt_lvl | output | 2 | Voltage reduction level, 0 nominal |
| rst_pulse | output | 1 | One-cycle module reset on entry to tier 3 |
| handoff_req | output | 1 | Request for redundant compute while in tier 3 |

## Verification
The tier, the two level codes and `rst_pulse` are all registered together. An epoch presented before a rising edge is therefore visible on every output just after that edge. `handoff_req` follows one edge later. The bench drives each epoch at a falling edge and removes it at the next falling edge. It samples at that second falling edge for level codes and `rst_pulse`, and one falling edge later for `handoff_req`. Escalation and calm scenarios compare the outputs after each individual epoch, so an off-by-one in either run count shows up at the exact epoch where the tier moves early or late.

// File: rtl/recov_pkg.sv
package recov_pkg;

    typedef enum logic [1:0] {
        TIER_NOM  = 2'd0,
        TIER_FREQ = 2'd1,
        TIER_FV   = 2'd2,
        TIER_CRIT = 2'd3
    } tier_e;

    typedef struct packed {
        logic [1:0] freq;
        logic [1:0] volt;
    } dvfs_lvl_t;

    localparam logic [1:0] SEV_CLEAR = 2'd0;

    function automatic dvfs_lvl_t tier_levels(tier_e t);
        dvfs_lvl_t l;
        case (t)
            TIER_FREQ: l = '{freq: 2'd1, volt: 2'd0};
            TIER_FV:   l = '{freq: 2'd2, volt: 2'd1};
            TIER_CRIT: l = '{freq: 2'd3, volt: 2'd2};
            default:   l = '{freq: 2'd0, volt: 2'd0};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/recov_esc_track.sv
module recov_esc_track #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic epoch,
    input  logic above,
    input  logic restart,
    output logic fire
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt;

    assign fire = epoch && above && (cnt >= CW'(HOLD - 1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (epoch) begin
            if (above) cnt <= cnt + 1'b1;
            else       cnt <= '0;
        end
    end
endmodule

// File: rtl/recov_calm_timer.sv
module recov_calm_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          epoch,
    input  logic          quiet,
    input  logic          restart,
    input  logic [CW-1:0] period,
    output logic          fire
);
    logic [CW-1:0] cnt;
    logic [CW:0]   need;
    logic [CW:0]   seen;

    assign need = (period == '0) ? (CW+1)'(1) : {1'b0, period};
    assign seen = {1'b0, cnt} + 1'b1;
    assign fire = epoch && quiet && (seen >= need);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (epoch) begin
            if (quiet) cnt <= cnt + 1'b1;
            else       cnt <= '0;
        end
    end
endmodule

// File: rtl/recov_out_stage.sv
module recov_out_stage
    import recov_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tier_e      tier_cur,
    input  tier_e      tier_nxt,
    output logic [1:0] freq_lvl,
    output logic [1:0] volt_lvl,
    output logic       rst_pulse,
    output logic       handoff_req
);
    dvfs_lvl_t lvl_q;

    assign freq_lvl = lvl_q.freq;
    assign volt_lvl = lvl_q.volt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q       <= '0;
            rst_pulse   <= 1'b0;
            handoff_req <= 1'b0;
        end else begin
            lvl_q       <= tier_levels(tier_nxt);
            rst_pulse   <= (tier_nxt == TIER_CRIT) && (tier_cur != TIER_CRIT);
            handoff_req <= (tier_nxt == TIER_CRIT) && (tier_cur == TIER_CRIT);
        end
    end
endmodule

// File: rtl/recov_ctrl.sv
module recov_ctrl
    import recov_pkg::*;
#(
    parameter int ESC_HOLD = 2,
    parameter int CALM_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sev_valid,
    input  logic [1:0]        sev,
    input  logic [CALM_W-1:0] calm_period,
    output logic [1:0]        freq_lvl,
    output logic [1:0]        volt_lvl,
    output logic              rst_pulse,
    output logic              handoff_req
);
    tier_e tier_q;
    tier_e tier_n;
    logic  above;
    logic  quiet;
    logic  esc_fire;
    logic  calm_fire;
    logic  tier_chg;

    assign above    = sev > tier_q;
    assign quiet    = (sev == SEV_CLEAR) && (tier_q != TIER_NOM);
    assign tier_chg = esc_fire || calm_fire;

    recov_esc_track #(.HOLD(ESC_HOLD)) u_esc (
        .clk     (clk),
        .rst     (rst),
        .epoch   (sev_valid),
        .above   (above),
        .restart (tier_chg),
        .fire    (esc_fire)
    );

    recov_calm_timer #(.CW(CALM_W)) u_calm (
        .clk     (clk),
        .rst     (rst),
        .epoch   (sev_valid),
        .quiet   (quiet),
        .restart (tier_chg),
        .period  (calm_period),
        .fire    (calm_fire)
    );

    always_comb begin
        tier_n = tier_q;
        if (esc_fire)       tier_n = tier_e'(sev);
        else if (calm_fire) tier_n = tier_e'(tier_q - 2'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) tier_q <= TIER_NOM;
        else     tier_q <= tier_n;
    end

    recov_out_stage u_out (
        .clk         (clk),
        .rst         (rst),
        .tier_cur    (tier_q),
        .tier_nxt    (tier_n),
        .freq_lvl    (freq_lvl),
        .volt_lvl    (volt_lvl),
        .rst_pulse   (rst_pulse),
        .handoff_req (handoff_req)
    );
endmodule

// File: rtl/recov_ctrl_chk.sv
module recov_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sev_valid,
    input logic [1:0] sev,
    input logic [1:0] tier_q,
    input logic [1:0] freq_lvl,
    input logic [1:0] volt_lvl,
    input logic       rst_pulse,
    input logic       handoff_req
);
    AST_TIER1_CODES: assert property (@(posedge clk) disable iff (rst)
        (tier_q == 2'd1) |-> (freq_lvl == 2'd1 && volt_lvl == 2'd0)); // R4

    AST_TIER2_CODES: assert property (@(posedge clk) disable iff (rst)
        (tier_q == 2'd2) |-> (freq_lvl == 2'd2 && volt_lvl == 2'd1)); // R5

    AST_RST_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |-> (tier_q == 2'd3 && $past(tier_q) != 2'd3)); // R6

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> !rst_pulse); // R6

    AST_HANDOFF_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $rose(handoff_req) |-> $past(rst_pulse)); // R6

    AST_HANDOFF_IN_CRIT: assert property (@(posedge clk) disable iff (rst)
        handoff_req |-> tier_q == 2'd3); // R9

    AST_ONE_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (tier_q < $past(tier_q)) |-> (tier_q == $past(tier_q) - 2'd1)); // R9

    AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (tier_q < $past(tier_q)) |-> ($past(sev_valid) && $past(sev) == 2'd0)); // R7

    AST_RISE_NEEDS_EPOCH: assert property (@(posedge clk) disable iff (rst)
        (tier_q > $past(tier_q)) |-> ($past(sev_valid) && $past(sev) == tier_q)); // R3
endmodule

bind recov_ctrl recov_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sev_valid   (sev_valid),
    .sev         (sev),
    .tier_q      (tier_q),
    .freq_lvl    (freq_lvl),
    .volt_lvl    (volt_lvl),
    .rst_pulse   (rst_pulse),
    .handoff_req (handoff_req)
);

// File: tb/tb_recov_ctrl.sv
module tb_recov_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sev_valid = 1'b0;
    logic [1:0] sev = 2'd0;
    logic [7:0] calm_period = 8'd3;
    logic [1:0] freq_lvl;
    logic [1:0] volt_lvl;
    logic       rst_pulse;
    logic       handoff_req;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    recov_ctrl #(.ESC_HOLD(2), .CALM_W(8)) dut (
        .clk         (clk),
        .rst         (rst),
        .sev_valid   (sev_valid),
        .sev         (sev),
        .calm_period (calm_period),
        .freq_lvl    (freq_lvl),
        .volt_lvl    (volt_lvl),
        .rst_pulse   (rst_pulse),
        .handoff_req (handoff_req)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic epoch(input logic [1:0] s);
        sev_valid = 1'b1;
        sev = s;
        @(negedge clk);
        sev_valid = 1'b0;
        sev = 2'd0;
    endtask

    task automatic levels(input string req, input int f, input int v);
        check(req, freq_lvl, f);
        check(req, volt_lvl, v);
    endtask

    task automatic t_reset;
        levels("R1 levels", 0, 0);
        check("R1 rst_pulse", rst_pulse, 0);
        check("R1 handoff", handoff_req, 0);
    endtask

    task automatic t_esc_tier1;
        epoch(2'd1);
        levels("R3 single epoch holds", 0, 0);
        epoch(2'd1);
        levels("R4 tier1 codes", 1, 0);
    endtask

    task automatic t_esc_restart;
        epoch(2'd2);
        epoch(2'd1);
        epoch(2'd2);
        levels("R3 run restarted", 1, 0);
        epoch(2'd2);
        levels("R5 tier2 codes", 2, 1);
    endtask

    task automatic t_invalid;
        sev = 2'd3;
        repeat (5) @(negedge clk);
        sev = 2'd0;
        levels("R10 invalid ignored", 2, 1);
        check("R10 no reset", rst_pulse, 0);
    endtask

    task automatic t_crit;
        epoch(2'd3);
        levels("R3 one critical epoch", 2, 1);
        epoch(2'd3);
        levels("R6 tier3 codes", 3, 2);
        check("R6 rst_pulse entry", rst_pulse, 1);
        check("R6 handoff not yet", handoff_req, 0);
        @(negedge clk);
        check("R6 rst_pulse single", rst_pulse, 0);
        check("R6 handoff rises", handoff_req, 1);
        repeat (3) @(negedge clk);
        check("R6 handoff held", handoff_req, 1);
    endtask

    task automatic t_calm;
        calm_period = 8'd3;
        epoch(2'd0);
        epoch(2'd0);
        epoch(2'd3);
        levels("R8 crit epoch holds tier", 3, 2);
        check("R8 no second pulse", rst_pulse, 0);
        epoch(2'd0);
        epoch(2'd0);
        levels("R8 calm count cleared", 3, 2);
        epoch(2'd0);
        levels("R7 step to tier2", 2, 1);
        check("R9 handoff drops", handoff_req, 0);
        epoch(2'd0);
        epoch(2'd0);
        levels("R7 count restarted", 2, 1);
        epoch(2'd0);
        levels("R9 step to tier1", 1, 0);
        epoch(2'd1);
        epoch(2'd0);
        epoch(2'd0);
        levels("R8 same-tier epoch clears calm", 1, 0);
        epoch(2'd0);
        levels("R7 step to nominal", 0, 0);
    endtask

    task automatic t_period_zero;
        calm_period = 8'd0;
        epoch(2'd1);
        epoch(2'd1);
        levels("R4 re-enter tier1", 1, 0);
        epoch(2'd0);
        levels("R7 period 0 acts as 1", 0, 0);
    endtask

    task automatic t_direct_jump;
        calm_period = 8'd1;
        epoch(2'd2);
        epoch(2'd3);
        levels("R3 jump to last severity", 3, 2);
        check("R6 pulse on jump", rst_pulse, 1);
        epoch(2'd0);
        levels("R9 one step from tier3", 2, 1);
        check("R9 handoff never held", handoff_req, 0);
        epoch(2'd0);
        levels("R9 one step from tier2", 1, 0);
        epoch(2'd0);
        levels("R9 back to nominal", 0, 0);
        epoch(2'd0);
        levels("R2 clear at nominal", 0, 0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_esc_tier1();
        t_esc_restart();
        t_invalid();
        t_crit();
        t_calm();
        t_period_zero();
        t_direct_jump();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end
endmodule